// File: doc/BRIEF.md
# DSI Command Packet Port

This block is the command-side packet path of a DSI host controller, reached through a small word-wide register port. To send a packet, software first loads the payload into a transmit word FIFO. It then writes the packet header, and that write commits the packet. A serializer turns the committed packet into a byte stream toward the link layer. The three header bytes go first. For long packets, the number of payload bytes named by the header's word count follows, taken from the queued words lowest byte first. ECC, CRC, lane distribution and the PHY sit downstream and are not part of this block.

For reads, the link layer hands back a 24-bit packet header and any payload as 32-bit words. Software polls a status register for busy, FIFO-not-empty and read-data-available. It then reads the returned header and pops the payload words one register read at a time. Short and long responses share the same header register: only the meaning of bits 23:8 differs with the data type.

Top module: `dsi_cmd_port`

## Requirements
- R1: After reset, the status register reads zero, the receive header register reads zero, a receive payload read returns zero, and `tx_valid` is low.
- R2: A write to address 1 commits a packet. Its bytes leave in the order bits 7:0 (data type in bits 5:0), bits 15:8, bits 23:16. Bit 24 of that write appears on `tx_lp` for every byte of the packet.
- R3: A packet counts as long when the low nibble of its 6-bit data type is between 0x9 and 0xE inclusive. A short packet emits only its three header bytes, and queued payload words stay in the FIFO for later packets.
- R4: A long packet with word count N emits exactly N payload bytes after the header. Byte k is byte (k mod 4) of the (k/4)-th queued word, where byte 0 is bits 7:0. The unused bytes of the last word are discarded.
- R5: Status bit 16 (busy) is set from the cycle after the header write until the last byte of the packet is accepted. `tx_last` is high only on the final byte.
- R6: A header write while busy is ignored: no second packet is emitted.
- R7: A write to address 0 while the transmit FIFO holds the parameter depth of words is dropped, and status bit 0 (overflow) becomes set and stays set until reset.
- R8: When a long packet needs a payload word and the transmit FIFO is empty, `tx_valid` stays low. Emission resumes once a word is written.
- R9: Status bit 17 is set whenever the transmit or the receive FIFO holds at least one word.
- R10: A pulse on `rx_hdr_valid` stores `rx_hdr`. Address 3 then reads it back in bits 23:0, and status bit 18 (read data available) becomes set.
- R11: Each read of address 4 pops one received payload word in arrival order; it returns zero when the FIFO is empty. Status bit 18 clears once address 3 has been read and the receive FIFO is empty.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold their values and `tx_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on addresses 3 and 4) |
| reg_addr | input | ADDR_W | Word address: 0 tx payload, 1 tx header, 2 status, 3 rx header, 4 rx payload |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address, combinational |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Link layer accepts the byte |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_lp | output | 1 | Packet is to be sent in low-power mode |
| rx_hdr_valid | input | 1 | Returned header strobe |
| rx_hdr | input | 24 | Returned header: type, then two data bytes or word count |
| rx_pld_valid | input | 1 | Returned payload word strobe |
| rx_pld | input | 32 | Returned payload word, lowest byte first |

## Verification
A wrong serializer state shows up on the byte stream itself: a stale byte index or remaining count gives a shifted, missing or extra byte within the same packet. It also moves `tx_last` off the final byte and leaves busy set or cleared too early in the next status read. A wrong FIFO pointer shows up one packet later, as payload bytes from the wrong word, or as a dropped or duplicated word after overflow. Receive-side state errors show up at the next status or payload read as a read-data-available bit that never clears or a word returned out of order. Random packets with random link backpressure are compared byte by byte against a model built from the header alone.

// File: rtl/dsi_cmd_pkg.sv
package dsi_cmd_pkg;

  typedef enum logic [1:0] {
    SER_IDLE = 2'd0,
    SER_HDR  = 2'd1,
    SER_PLD  = 2'd2
  } ser_state_e;

  // register word addresses
  localparam int A_TX_PLD = 0;
  localparam int A_TX_HDR = 1;
  localparam int A_STATUS = 2;
  localparam int A_RX_HDR = 3;
  localparam int A_RX_PLD = 4;

  localparam int HDR_LAST_IDX = 2;

  // long packet: low nibble of data type in 0x9..0xE
  function automatic logic dt_is_long(input logic [5:0] dt);
    return (dt[3:0] >= 4'h9) && (dt[3:0] <= 4'hE);
  endfunction

endpackage

// File: rtl/dsi_rst_sync.sv
module dsi_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/dsi_word_fifo.sv
module dsi_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign rdata = mem[rptr_q];

  always_comb begin
    do_push = push && !full;
    do_pop  = pop && !empty;
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    cnt_d   = cnt_q;
    if (do_push) wptr_d = (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (do_pop)  rptr_d = (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // storage carries no reset; written only under its enable
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= wdata;
  end

endmodule

// File: rtl/dsi_tx_serializer.sv
module dsi_tx_serializer #(
  parameter int WC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [23:0]     hdr_i,
  input  logic            lp_i,
  input  logic [31:0]     word_i,
  input  logic            word_ok_i,
  input  logic            ready_i,
  output logic            pop_o,
  output logic            valid_o,
  output logic [7:0]      data_o,
  output logic            last_o,
  output logic            lp_o,
  output logic            busy_o
);
  import dsi_cmd_pkg::*;

  ser_state_e        state_q, state_d;
  logic [23:0]       hdr_q, hdr_d;
  logic              lp_q, lp_d;
  logic [1:0]        idx_q, idx_d;
  logic [WC_W-1:0]   rem_q, rem_d;
  logic              fire;

  always_comb begin
    state_d = state_q;
    hdr_d   = hdr_q;
    lp_d    = lp_q;
    idx_d   = idx_q;
    rem_d   = rem_q;
    valid_o = 1'b0;
    data_o  = 8'h00;
    last_o  = 1'b0;
    pop_o   = 1'b0;
    fire    = 1'b0;
    unique case (state_q)
      SER_IDLE: begin
        if (start_i) begin
          state_d = SER_HDR;
          hdr_d   = hdr_i;
          lp_d    = lp_i;
          idx_d   = '0;
          rem_d   = dt_is_long(hdr_i[5:0]) ? WC_W'(hdr_i[23:8]) : '0;
        end
      end
      SER_HDR: begin
        valid_o = 1'b1;
        unique case (idx_q)
          2'd0:    data_o = hdr_q[7:0];
          2'd1:    data_o = hdr_q[15:8];
          default: data_o = hdr_q[23:16];
        endcase
        last_o = (idx_q == 2'(HDR_LAST_IDX)) && (rem_q == '0);
        fire   = ready_i;
        if (fire) begin
          if (idx_q == 2'(HDR_LAST_IDX)) begin
            idx_d   = '0;
            state_d = (rem_q == '0) ? SER_IDLE : SER_PLD;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      SER_PLD: begin
        valid_o = word_ok_i;
        unique case (idx_q)
          2'd0: data_o = word_i[7:0];
          2'd1: data_o = word_i[15:8];
          2'd2: data_o = word_i[23:16];
          default: data_o = word_i[31:24];
        endcase
        last_o = (rem_q == WC_W'(1));
        fire   = word_ok_i && ready_i;
        if (fire) begin
          rem_d = rem_q - 1'b1;
          pop_o = (rem_q == WC_W'(1)) || (idx_q == 2'd3);
          idx_d = idx_q + 1'b1;
          if (rem_q == WC_W'(1)) begin
            idx_d   = '0;
            state_d = SER_IDLE;
          end
        end
      end
      default: state_d = SER_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SER_IDLE;
      hdr_q   <= '0;
      lp_q    <= 1'b0;
      idx_q   <= '0;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      hdr_q   <= hdr_d;
      lp_q    <= lp_d;
      idx_q   <= idx_d;
      rem_q   <= rem_d;
    end
  end

  assign lp_o   = lp_q;
  assign busy_o = (state_q != SER_IDLE);

endmodule

// File: rtl/dsi_cmd_port.sv
module dsi_cmd_port #(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              tx_lp,
  input  logic              rx_hdr_valid,
  input  logic [23:0]       rx_hdr,
  input  logic              rx_pld_valid,
  input  logic [31:0]       rx_pld
);
  import dsi_cmd_pkg::*;

  localparam int WORD_W = 32;
  localparam int WC_W   = 16;

  logic              rst_n_s;
  logic              pld_wr, hdr_wr, hdr_rd, pld_rd, start;
  logic              tx_busy, tx_full, tx_empty, tx_pop;
  logic [WORD_W-1:0] tx_head;
  logic              rx_empty, unused_rx_full;
  logic [WORD_W-1:0] rx_head;
  logic              ovf_q, ovf_d;
  logic [23:0]       rxh_q, rxh_d;
  logic              unread_q, unread_d;
  logic              rd_avail, fifo_ne;
  logic [31:0]       status;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata[31:25];

  dsi_rst_sync i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_n_s)
  );

  // register strobes
  always_comb begin
    pld_wr = reg_wr && (reg_addr == ADDR_W'(A_TX_PLD));
    hdr_wr = reg_wr && (reg_addr == ADDR_W'(A_TX_HDR));
    hdr_rd = reg_rd && (reg_addr == ADDR_W'(A_RX_HDR));
    pld_rd = reg_rd && (reg_addr == ADDR_W'(A_RX_PLD));
    start  = hdr_wr && !tx_busy;
  end

  dsi_word_fifo #(.W(WORD_W), .DEPTH(TX_DEPTH)) i_tx_fifo (
    .clk   (clk),
    .rst_n (rst_n_s),
    .push  (pld_wr),
    .wdata (reg_wdata),
    .pop   (tx_pop),
    .rdata (tx_head),
    .full  (tx_full),
    .empty (tx_empty)
  );

  dsi_tx_serializer #(.WC_W(WC_W)) i_ser (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start_i   (start),
    .hdr_i     (reg_wdata[23:0]),
    .lp_i      (reg_wdata[24]),
    .word_i    (tx_head),
    .word_ok_i (!tx_empty),
    .ready_i   (tx_ready),
    .pop_o     (tx_pop),
    .valid_o   (tx_valid),
    .data_o    (tx_data),
    .last_o    (tx_last),
    .lp_o      (tx_lp),
    .busy_o    (tx_busy)
  );

  dsi_word_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) i_rx_fifo (
    .clk   (clk),
    .rst_n (rst_n_s),
    .push  (rx_pld_valid),
    .wdata (rx_pld),
    .pop   (pld_rd),
    .rdata (rx_head),
    .full  (unused_rx_full),
    .empty (rx_empty)
  );

  // next state for flags and the receive header holder
  always_comb begin
    ovf_d    = ovf_q | (pld_wr && tx_full);
    rxh_d    = rxh_q;
    unread_d = unread_q;
    if (rx_hdr_valid) begin
      rxh_d    = rx_hdr;
      unread_d = 1'b1;
    end else if (hdr_rd) begin
      unread_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ovf_q    <= 1'b0;
      rxh_q    <= '0;
      unread_q <= 1'b0;
    end else begin
      ovf_q    <= ovf_d;
      rxh_q    <= rxh_d;
      unread_q <= unread_d;
    end
  end

  assign rd_avail = unread_q | !rx_empty;
  assign fifo_ne  = !tx_empty | !rx_empty;
  assign status   = {13'd0, rd_avail, fifo_ne, tx_busy, 15'd0, ovf_q};

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(A_STATUS))      reg_rdata = status;
    else if (reg_addr == ADDR_W'(A_RX_HDR)) reg_rdata = {8'd0, rxh_q};
    else if (reg_addr == ADDR_W'(A_RX_PLD)) reg_rdata = rx_empty ? '0 : rx_head;
  end

endmodule

// File: rtl/dsi_cmd_port_chk.sv
module dsi_cmd_port_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic [7:0] tx_data,
  input logic tx_last,
  input logic tx_lp,
  input logic tx_busy,
  input logic ovf,
  input logic pld_wr,
  input logic tx_full,
  input logic rx_hdr_valid,
  input logic rd_avail
);

  // R12: output held under backpressure
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R5: a valid byte only while a packet is in flight
  assert_valid_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_busy);

  // R5: accepting the final byte ends busy
  assert_last_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> !tx_busy);

  // R6: busy cannot end (or restart) before the final byte is accepted
  assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !(tx_valid && tx_ready && tx_last)) |=> tx_busy);

  // R2: low-power flag constant within a packet
  assert_lp_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && $past(tx_busy)) |-> $stable(tx_lp));

  // R7: overflow is sticky
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R7: overflow rises only after a write into a full FIFO
  assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(pld_wr && tx_full));

  // R10: returned header makes read data available
  assert_rdavail_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hdr_valid |=> rd_avail);

endmodule

bind dsi_cmd_port dsi_cmd_port_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .tx_data      (tx_data),
  .tx_last      (tx_last),
  .tx_lp        (tx_lp),
  .tx_busy      (tx_busy),
  .ovf          (ovf_q),
  .pld_wr       (pld_wr),
  .tx_full      (tx_full),
  .rx_hdr_valid (rx_hdr_valid),
  .rd_avail     (rd_avail)
);

// File: tb/test_dsi_cmd_port.sv
module test_dsi_cmd_port;

  localparam int TXD = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        tx_valid, tx_ready, tx_last, tx_lp;
  logic [7:0]  tx_data;
  logic        rx_hdr_valid, rx_pld_valid;
  logic [23:0] rx_hdr;
  logic [31:0] rx_pld;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  bit rand_rdy = 1'b0;
  logic hold_rdy = 1'b1;

  logic [7:0]  cap_d[$];
  bit          cap_lp[$];
  bit          cap_last[$];
  logic [7:0]  exp_d[$];
  logic [31:0] pw[TXD];

  always #4 clk = ~clk;

  dsi_cmd_port i_dsi_cmd_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .tx_lp(tx_lp), .rx_hdr_valid(rx_hdr_valid),
    .rx_hdr(rx_hdr), .rx_pld_valid(rx_pld_valid), .rx_pld(rx_pld)
  );

  // link-side ready, changed shortly after each rising edge
  always @(posedge clk) begin
    #2;
    tx_ready = rand_rdy ? 1'($urandom % 2) : hold_rdy;
  end

  // byte monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      cap_d.push_back(tx_data);
      cap_lp.push_back(tx_lp);
      cap_last.push_back(tx_last);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int g = 0;
    do begin
      rd(3'd2, s);
      g++;
    end while (s[16] && g < 3000);
  endtask

  function automatic bit is_long(input logic [5:0] dt);
    return (dt[3:0] >= 4'h9) && (dt[3:0] <= 4'hE);
  endfunction

  task automatic start_pkt(input logic [5:0] dt, input logic [15:0] wc, input bit lp, input int nw);
    cap_d.delete(); cap_lp.delete(); cap_last.delete();
    for (int i = 0; i < nw; i++) wr(3'd0, pw[i]);
    wr(3'd1, {7'd0, lp, wc, 2'b00, dt});
  endtask

  task automatic build_exp(input logic [5:0] dt, input logic [15:0] wc);
    exp_d.delete();
    exp_d.push_back({2'b00, dt});
    exp_d.push_back(wc[7:0]);
    exp_d.push_back(wc[15:8]);
    if (is_long(dt))
      for (int k = 0; k < int'(wc); k++) exp_d.push_back(pw[k/4][8*(k%4) +: 8]);
  endtask

  task automatic finish_pkt(input logic [5:0] dt, input logic [15:0] wc, input bit lp, input string req);
    wait_idle();
    build_exp(dt, wc);
    chk(cap_d.size() == exp_d.size(), {req, " byte count"}, cap_d.size(), exp_d.size());
    if (cap_d.size() == exp_d.size()) begin
      for (int i = 0; i < exp_d.size(); i++) begin
        chk(cap_d[i] == exp_d[i], {req, " byte"}, cap_d[i], exp_d[i]);
        chk(cap_lp[i] == lp, "R2 lp flag", cap_lp[i], lp);
        chk(cap_last[i] == (i == exp_d.size() - 1), "R5 last flag", cap_last[i], (i == exp_d.size() - 1));
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] s, d;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    rx_hdr_valid = 1'b0; rx_pld_valid = 1'b0; rx_hdr = '0; rx_pld = '0;
    tx_ready = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
    rd(3'd2, s); chk(s == 32'd0, "R1 status", s, 0);
    rd(3'd3, s); chk(s == 32'd0, "R1 rx header", s, 0);
    rd(3'd4, s); chk(s == 32'd0, "R1 rx payload", s, 0);

    // R2 R4 R5: long packet, partial final word, low-power
    pw[0] = 32'h44332211; pw[1] = 32'hCCBBAA55;
    start_pkt(6'h39, 16'd5, 1'b1, 2);
    rd(3'd2, s); chk(s[16] == 1'b1, "R5 busy after commit", s, 32'h10000);
    finish_pkt(6'h39, 16'd5, 1'b1, "R4 long");
    rd(3'd2, s); chk(s == 32'd0, "R5 R9 idle status", s, 0);

    // R3: short packet leaves queued word; R9 sees it
    pw[0] = 32'hDDCCBBAA;
    start_pkt(6'h15, 16'h12AB, 1'b0, 1);
    finish_pkt(6'h15, 16'h12AB, 1'b0, "R3 short");
    rd(3'd2, s); chk(s[17] == 1'b1, "R3 R9 word kept", s, 32'h20000);
    start_pkt(6'h29, 16'd2, 1'b0, 0);
    finish_pkt(6'h29, 16'd2, 1'b0, "R3 leftover used");
    rd(3'd2, s); chk(s[17] == 1'b0, "R9 fifo empty", s, 0);

    // R4: long with zero word count
    start_pkt(6'h09, 16'd0, 1'b1, 0);
    finish_pkt(6'h09, 16'd0, 1'b1, "R4 zero count");

    // R6: header while busy is ignored
    hold_rdy = 1'b0;
    pw[0] = 32'h0A0B0C0D;
    start_pkt(6'h29, 16'd3, 1'b0, 1);
    wr(3'd1, 32'h01000005);
    repeat (3) @(negedge clk);
    hold_rdy = 1'b1;
    finish_pkt(6'h29, 16'd3, 1'b0, "R6 first packet only");
    repeat (6) @(negedge clk);
    chk(tx_valid == 1'b0, "R6 no second packet", tx_valid, 0);
    chk(cap_d.size() == 6, "R6 byte total", cap_d.size(), 6);

    // R8: stall on empty payload FIFO
    pw[0] = 32'h87654321;
    start_pkt(6'h39, 16'd4, 1'b0, 0);
    repeat (10) @(negedge clk);
    chk(tx_valid == 1'b0, "R8 stalled", tx_valid, 0);
    chk(cap_d.size() == 3, "R8 header only so far", cap_d.size(), 3);
    wr(3'd0, pw[0]);
    finish_pkt(6'h39, 16'd4, 1'b0, "R8 resumed");

    // R7: overflow drop and sticky flag
    for (int i = 0; i < TXD; i++) pw[i] = 32'h10101010 * (i + 1);
    for (int i = 0; i < TXD; i++) wr(3'd0, pw[i]);
    rd(3'd2, s); chk(s[0] == 1'b0, "R7 no overflow yet", s, 0);
    wr(3'd0, 32'hDEADBEEF);
    rd(3'd2, s); chk(s[0] == 1'b1 && s[17] == 1'b1, "R7 overflow set", s, 32'h20001);
    start_pkt(6'h39, 16'(4 * TXD), 1'b0, 0);
    finish_pkt(6'h39, 16'(4 * TXD), 1'b0, "R7 dropped word absent");
    rd(3'd2, s); chk(s == 32'd1, "R7 sticky", s, 1);

    // random packets with random backpressure
    rand_rdy = 1'b1;
    for (int n = 0; n < 40; n++) begin
      logic [5:0]  dt;
      logic [15:0] wc;
      bit          lp;
      int          nw;
      dt = 6'($urandom);
      lp = 1'($urandom);
      wc = is_long(dt) ? 16'($urandom % (4 * TXD + 1)) : 16'($urandom);
      nw = is_long(dt) ? (int'(wc) + 3) / 4 : 0;
      for (int i = 0; i < TXD; i++) pw[i] = $urandom;
      start_pkt(dt, wc, lp, nw);
      finish_pkt(dt, wc, lp, is_long(dt) ? "R4 random long" : "R3 random short");
    end
    rand_rdy = 1'b0;

    // R10 R11: short response
    @(negedge clk); rx_hdr_valid = 1'b1; rx_hdr = 24'h341221;
    @(negedge clk); rx_hdr_valid = 1'b0;
    rd(3'd2, s); chk(s[18] == 1'b1, "R10 read data available", s, 32'h40000);
    rd(3'd3, s); chk(s == 32'h00341221, "R10 short header", s, 32'h00341221);
    rd(3'd2, s); chk(s[18] == 1'b0, "R11 available cleared", s, 0);

    // R10 R11: long response, word count 6
    @(negedge clk);
    rx_hdr_valid = 1'b1; rx_hdr = 24'h00061A;
    rx_pld_valid = 1'b1; rx_pld = 32'h44332211;
    @(negedge clk);
    rx_hdr_valid = 1'b0; rx_pld = 32'h00006655;
    @(negedge clk);
    rx_pld_valid = 1'b0;
    rd(3'd2, s); chk(s[18:17] == 2'b11, "R9 R10 status", s, 32'h60000);
    rd(3'd3, s); chk(s == 32'h0000061A, "R10 long header", s, 32'h0000061A);
    rd(3'd2, s); chk(s[18] == 1'b1, "R11 still available", s, 32'h40000);
    rd(3'd4, d); chk(d == 32'h44332211, "R11 first word", d, 32'h44332211);
    rd(3'd4, d); chk(d == 32'h00006655, "R11 second word", d, 32'h00006655);
    rd(3'd2, s); chk(s[18:17] == 2'b00, "R11 drained", s, 0);
    rd(3'd4, d); chk(d == 32'd0, "R11 empty read", d, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule